// File: doc/BRIEF.md
# DMA Transfer Width Sequencer

This block turns one DMA byte run, given as a start address and a byte count, into a series of bus cycles, each one or two bytes wide. For every cycle it works out from the current address parity and the bytes still owed whether a 16-bit cycle is legal. It issues a 16-bit cycle when it is legal and a single-byte cycle otherwise. A byte-mode flag, taken when the run starts, turns off 16-bit cycles for the whole run.

For each cycle the block presents the address, a wide/narrow size flag, the two byte lane enables and the write data. The data is steered onto the lanes by a byte-order strap. The bus master takes a cycle by raising `cyc_ready` while `cyc_valid` is high. The address then advances by the cycle size and the remaining count drops by the same amount. One cycle after the final transfer a single-cycle `done` pulse marks the end of the run. The data source supplies the next two stream bytes on `src_data` with the first byte in bits 7:0. Arbitration and buffering belong to the surrounding logic.

Top module: `dmaw_seq_top`

## Requirements
- R1: While reset is held and after its release, `busy`, `cyc_valid` and `done` are low until a run is started.
- R2: A `start` pulse is taken only while `busy` is low. The run loads `start_addr`, `start_len` and `start_bmode`. A non-zero length raises `busy` and `cyc_valid` on the next cycle. A `start` pulse during a run has no effect on the cycles.
- R3: With byte mode off, a cycle at an even address with two or more bytes left is wide: `cyc_wide`=1 and `cyc_be`=2'b11.
- R4: A cycle with exactly one byte left is narrow (`cyc_wide`=0).
- R5: A cycle at an odd address is narrow. The following cycle is at an even address and may be wide again.
- R6: A run started with `start_bmode`=1 issues only narrow cycles. The flag is read only on the `start` cycle, so changing `start_bmode` during a run has no effect.
- R7: A narrow cycle enables exactly one lane: lane index = address bit 0 XOR `swap_strap`. Lane 0 is `cyc_data[7:0]` / `cyc_be[0]`. The byte from `src_data[7:0]` is placed on that lane, and the disabled lane carries zero.
- R8: In a wide cycle, `src_data[7:0]` goes on lane 0 and `src_data[15:8]` on lane 1 when `swap_strap`=0. When `swap_strap`=1 the two bytes are exchanged.
- R9: The address and count change only on a handshake (`cyc_valid` and `cyc_ready`). On a handshake they move by 2 for a wide cycle and by 1 for a narrow one. While `cyc_ready` is low the cycle is held unchanged.
- R10: The cycle after the handshake that brings the count to zero, `done` is high for exactly one cycle and `busy` is low. A `start` with length zero gives that `done` pulse on the next cycle with no bus cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Starts a run when idle |
| start_addr | input | ADDR_W | First byte address of the run |
| start_len | input | CNT_W | Number of bytes in the run |
| start_bmode | input | 1 | 1 = narrow cycles only for this run |
| swap_strap | input | 1 | Byte-order strap for lane steering |
| src_data | input | 16 | Next two stream bytes, first byte in [7:0] |
| cyc_ready | input | 1 | Bus master takes the offered cycle |
| busy | output | 1 | A run is in progress |
| cyc_valid | output | 1 | A bus cycle is offered |
| cyc_addr | output | ADDR_W | Address of the offered cycle |
| cyc_wide | output | 1 | 1 = 16-bit cycle, 0 = 8-bit cycle |
| cyc_be | output | 2 | Byte lane enables, bit 0 = low lane |
| cyc_data | output | 16 | Lane-steered write data |
| done | output | 1 | One-cycle pulse after the last transfer |

## Verification
The assertions assume that `cyc_ready` is only meaningful while `cyc_valid` is high. They also assume that `swap_strap` is a static strap that changes only between runs. The lane checks hold for any strap value, but the bench only moves it while idle. The bench issues extra `start` pulses and toggles `start_bmode` during runs, so those inputs are checked to have no effect. `cyc_ready` is driven either always high or from a random pattern with long stalls. Runs cover even and odd start addresses and lengths 0, 1, 2 and above, so every width decision path is reached.

// File: rtl/dmaw_pkg.sv
package dmaw_pkg;
  localparam int unsigned LANES  = 2;
  localparam int unsigned LANE_W = 8;

  typedef enum logic {
    SZ_BYTE = 1'b0,
    SZ_HALF = 1'b1
  } cyc_size_e;
endpackage

// File: rtl/dmaw_size_sel.sv
module dmaw_size_sel
  import dmaw_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic             addr_lsb,
  input  logic [CNT_W-1:0] remain,
  input  logic             bmode,
  output cyc_size_e        size
);
  localparam logic [CNT_W-1:0] HALF_BYTES = CNT_W'(2);

  logic room_for_half;

  always_comb begin
    room_for_half = (remain >= HALF_BYTES);
    if (!bmode && !addr_lsb && room_for_half) size = SZ_HALF;
    else                                      size = SZ_BYTE;
  end
endmodule

// File: rtl/dmaw_lane_map.sv
module dmaw_lane_map
  import dmaw_pkg::*;
(
  input  cyc_size_e                size,
  input  logic                     addr_lsb,
  input  logic                     swap,
  input  logic [LANES*LANE_W-1:0]  src,
  output logic [LANES-1:0]         be,
  output logic [LANES*LANE_W-1:0]  data
);
  logic first_lane;
  assign first_lane = addr_lsb ^ swap;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam logic LB = ((l % 2) == 1);
    logic pick;
    logic en;
    always_comb begin
      pick = LB ^ first_lane;
      en   = (size == SZ_HALF) || (LB == first_lane);
      be[l] = en;
      if (!en)       data[l*LANE_W +: LANE_W] = '0;
      else if (pick) data[l*LANE_W +: LANE_W] = src[LANE_W +: LANE_W];
      else           data[l*LANE_W +: LANE_W] = src[0 +: LANE_W];
    end
  end

  always_comb begin
    if (size == SZ_BYTE) begin
      a_r7_one_lane: assert ($countones(be) == 1)
        else $error("narrow cycle must enable one lane");
    end else begin
      a_r3_both_lanes: assert (be == '1)
        else $error("wide cycle must enable all lanes");
    end
  end
endmodule

// File: rtl/dmaw_run_ctrl.sv
module dmaw_run_ctrl
  import dmaw_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  start_len,
  input  logic              start_bmode,
  input  cyc_size_e         size,
  input  logic              cyc_ready,
  output logic              busy,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  remain,
  output logic              bmode,
  output logic              done
);
  localparam logic [ADDR_W-1:0] A_ONE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_TWO = ADDR_W'(2);
  localparam logic [CNT_W-1:0]  C_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0]  C_TWO = CNT_W'(2);

  logic              busy_q, busy_d;
  logic              done_q, done_d;
  logic              bmode_q, bmode_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              accept, xfer, run_en;
  logic [ADDR_W-1:0] a_step;
  logic [CNT_W-1:0]  c_step;

  always_comb begin
    accept  = start && !busy_q;
    xfer    = busy_q && cyc_ready;
    run_en  = accept || xfer;
    a_step  = (size == SZ_HALF) ? A_TWO : A_ONE;
    c_step  = (size == SZ_HALF) ? C_TWO : C_ONE;
    addr_d  = addr_q;
    cnt_d   = cnt_q;
    bmode_d = bmode_q;
    busy_d  = busy_q;
    done_d  = 1'b0;
    if (accept) begin
      addr_d  = start_addr;
      cnt_d   = start_len;
      bmode_d = start_bmode;
      busy_d  = (start_len != '0);
      done_d  = (start_len == '0);
    end else if (xfer) begin
      addr_d = addr_q + a_step;
      cnt_d  = cnt_q - c_step;
      if (cnt_q == c_step) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      cnt_q   <= '0;
      bmode_q <= 1'b0;
    end else if (run_en) begin
      addr_q  <= addr_d;
      cnt_q   <= cnt_d;
      bmode_q <= bmode_d;
    end
  end

  assign busy   = busy_q;
  assign addr   = addr_q;
  assign remain = cnt_q;
  assign bmode  = bmode_q;
  assign done   = done_q;

  a_r9_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !cyc_ready) |=> ($stable(addr_q) && $stable(cnt_q)))
    else $error("cycle moved without handshake");

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q)
    else $error("done longer than one cycle");

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q)
    else $error("done while busy");

  a_r6_bmode_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(bmode_q))
    else $error("byte mode changed within a run");

  a_r2_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start && !cyc_ready) |=> $stable(addr_q))
    else $error("start accepted while busy");
endmodule

// File: rtl/dmaw_seq_top.sv
module dmaw_seq_top
  import dmaw_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  start_len,
  input  logic              start_bmode,
  input  logic              swap_strap,
  input  logic [15:0]       src_data,
  input  logic              cyc_ready,
  output logic              busy,
  output logic              cyc_valid,
  output logic [ADDR_W-1:0] cyc_addr,
  output logic              cyc_wide,
  output logic [1:0]        cyc_be,
  output logic [15:0]       cyc_data,
  output logic              done
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              run_busy;
  logic [ADDR_W-1:0] run_addr;
  logic [CNT_W-1:0]  run_cnt;
  logic              run_bmode;
  cyc_size_e         cur_size;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  dmaw_run_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_run (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start      (start),
    .start_addr (start_addr),
    .start_len  (start_len),
    .start_bmode(start_bmode),
    .size       (cur_size),
    .cyc_ready  (cyc_ready),
    .busy       (run_busy),
    .addr       (run_addr),
    .remain     (run_cnt),
    .bmode      (run_bmode),
    .done       (done)
  );

  dmaw_size_sel #(.CNT_W(CNT_W)) u_size (
    .addr_lsb(run_addr[0]),
    .remain  (run_cnt),
    .bmode   (run_bmode),
    .size    (cur_size)
  );

  dmaw_lane_map u_lane (
    .size    (cur_size),
    .addr_lsb(run_addr[0]),
    .swap    (swap_strap),
    .src     (src_data),
    .be      (cyc_be),
    .data    (cyc_data)
  );

  assign busy      = run_busy;
  assign cyc_valid = run_busy;
  assign cyc_addr  = run_addr;
  assign cyc_wide  = (cur_size == SZ_HALF);

  a_r5_odd_narrow: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cyc_valid && cyc_addr[0]) |-> !cyc_wide)
    else $error("wide cycle at odd address");

  a_r4_last_narrow: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cyc_valid && run_cnt == CNT_W'(1)) |-> !cyc_wide)
    else $error("wide cycle with one byte left");

  a_r6_bmode_narrow: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cyc_valid && run_bmode) |-> !cyc_wide)
    else $error("wide cycle in byte mode");
endmodule

// File: tb/dmaw_seq_top_tb.sv
`timescale 1ns/1ps
module dmaw_seq_top_tb;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic [CNT_W-1:0]  start_len = '0;
  logic              start_bmode = 1'b0;
  logic              swap_strap = 1'b0;
  logic [15:0]       src_data = '0;
  logic              cyc_ready = 1'b0;
  logic              busy, cyc_valid, cyc_wide, done;
  logic [ADDR_W-1:0] cyc_addr;
  logic [1:0]        cyc_be;
  logic [15:0]       cyc_data;

  int checks = 0;
  int errors = 0;
  int rdy_mode = 0;
  int cycles = 0;
  bit finished = 0;

  // reference model state
  bit m_busy = 0, m_done = 0, m_bmode = 0;
  int m_addr = 0, m_cnt = 0;

  always #2 clk = ~clk;

  dmaw_seq_top #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .start_len(start_len), .start_bmode(start_bmode), .swap_strap(swap_strap),
    .src_data(src_data), .cyc_ready(cyc_ready), .busy(busy),
    .cyc_valid(cyc_valid), .cyc_addr(cyc_addr), .cyc_wide(cyc_wide),
    .cyc_be(cyc_be), .cyc_data(cyc_data), .done(done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_wide();
    return m_busy && !m_bmode && (m_addr % 2 == 0) && (m_cnt >= 2);
  endfunction

  // model update and per-cycle compare
  always begin
    @(posedge clk);
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_bmode = 0; m_addr = 0; m_cnt = 0;
    end else begin
      bit hs, acc;
      int stp;
      hs  = m_busy && cyc_ready;
      acc = start && !m_busy;
      stp = exp_wide() ? 2 : 1;
      m_done = 0;
      if (acc) begin
        m_addr = int'(start_addr); m_cnt = int'(start_len); m_bmode = start_bmode;
        m_busy = (start_len != 0); m_done = (start_len == 0);
      end else if (hs) begin
        m_addr = (m_addr + stp) % (1 << ADDR_W);
        m_cnt  = m_cnt - stp;
        if (m_cnt == 0) begin m_busy = 0; m_done = 1; end
      end
    end
    #1;
    if (rst_n) begin
      check(busy == m_busy && cyc_valid == m_busy, "R2 busy/valid", int'(busy), int'(m_busy));
      check(done == m_done, "R10 done", int'(done), int'(m_done));
      if (m_busy) begin
        bit w;
        int ln;
        logic [15:0] ed;
        logic [1:0]  eb;
        w = exp_wide();
        check(cyc_addr == ADDR_W'(m_addr), "R9 address", int'(cyc_addr), m_addr);
        if (m_bmode)            check(cyc_wide == w, "R6 byte mode size", int'(cyc_wide), int'(w));
        else if (m_addr % 2)    check(cyc_wide == w, "R5 odd size", int'(cyc_wide), int'(w));
        else if (m_cnt == 1)    check(cyc_wide == w, "R4 last byte size", int'(cyc_wide), int'(w));
        else                    check(cyc_wide == w, "R3 wide size", int'(cyc_wide), int'(w));
        if (w) begin
          eb = 2'b11;
          ed = swap_strap ? {src_data[7:0], src_data[15:8]} : src_data;
          check(cyc_be == eb, "R3 enables", int'(cyc_be), int'(eb));
          check(cyc_data == ed, "R8 wide data", int'(cyc_data), int'(ed));
        end else begin
          ln = (m_addr % 2) ^ int'(swap_strap);
          eb = (ln == 1) ? 2'b10 : 2'b01;
          ed = (ln == 1) ? {src_data[7:0], 8'h00} : {8'h00, src_data[7:0]};
          check(cyc_be == eb, "R7 lane enable", int'(cyc_be), int'(eb));
          check(cyc_data == ed, "R7 narrow data", int'(cyc_data), int'(ed));
        end
      end
    end
  end

  // input pattern drivers
  always @(negedge clk) begin
    src_data = 16'($urandom);
    if (rdy_mode == 0) cyc_ready = 1'b1;
    else               cyc_ready = ($urandom % 4) != 0;
  end

  task automatic run(input int a, input int n, input bit bm, input bit sw, input bit poke);
    @(negedge clk);
    swap_strap = sw;
    start_addr = ADDR_W'(a); start_len = CNT_W'(n); start_bmode = bm; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      @(negedge clk);
      start = 1'b1; start_addr = ADDR_W'(a + 5); start_len = CNT_W'(3);
      start_bmode = ~bm;
      @(negedge clk);
      start = 1'b0;
    end
    while (m_busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset held
    check(busy == 0 && cyc_valid == 0 && done == 0, "R1 reset state", int'({busy, cyc_valid, done}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy == 0 && cyc_valid == 0 && done == 0, "R1 after release", int'({busy, cyc_valid, done}), 0);

    rdy_mode = 0;
    run(16'h0100, 8, 0, 0, 0);   // R3 all wide
    run(16'h0101, 7, 0, 0, 0);   // R5 odd start then wide
    run(16'h0200, 5, 0, 1, 0);   // R4 trailing byte, R8 swapped
    run(16'h0303, 1, 0, 0, 0);   // single odd byte
    run(16'h0304, 1, 0, 1, 0);   // single even byte, swapped lane
    run(16'h0400, 0, 0, 0, 0);   // R10 zero length
    run(16'h0500, 6, 1, 0, 0);   // R6 byte mode
    run(16'h0501, 5, 1, 1, 0);   // R6 byte mode, swapped lanes
    run(16'h0600, 9, 0, 0, 1);   // R2 start ignored while busy
    run(16'h0700, 6, 1, 0, 1);   // R6 mode change mid-run ignored
    run(16'hFFFE, 4, 0, 0, 0);   // address wrap
    rdy_mode = 1;                // R9 stalls
    for (int i = 0; i < 40; i++)
      run(int'($urandom % 65536), int'($urandom % 20), bit'($urandom % 2),
          bit'($urandom % 2), bit'($urandom % 2));
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule